// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one read or write command into the sequence of column addresses that a synchronous DRAM burst visits. When a command arrives, it captures the starting column and the current mode settings: a length code, an ordering (sequential or interleaved), the command direction and a single-beat-write switch. From the next clock it issues one column per cycle, together with a valid flag and a last flag, until the burst runs out or a stop request ends it.

The ordering rule keeps every beat of a short burst inside the aligned block that holds the starting column. Sequential bursts count upward and wrap inside that block. Interleaved bursts flip the low column bits by the beat index. A full-page burst walks all columns, wraps from the top column to zero, and runs until it is stopped. When the single-beat-write switch is on, a write becomes a burst of one, and reads keep the programmed length. A new command is accepted on any clock and replaces the burst in progress, so the column address can change every cycle.

Top module: `burst_col_gen`

## Requirements
- R1: While rst_ni is low, valid_o and last_o are 0.
- R2: A command sampled with start_i high shows its start_col_i on col_o, with valid_o high, from the following clock. One beat follows per clock with no gaps. Length codes 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, and valid_o is 0 on the clock after the final beat.
- R3: With burst_type_i = 0 (sequential), the column bits below the burst length count up from the start value and wrap to zero. The bits above them keep the start value.
- R4: With burst_type_i = 1 (interleaved), beat k of a burst of length L issues start_col_i XOR (k mod L).
- R5: Length code 7 is full page. Columns count up by one, 511 wraps to 0, the burst continues until stopped, last_o stays 0, and burst_type_i has no effect.
- R6: When single_wr_i = 1 and cmd_write_i = 1 (write), the burst has exactly one beat at start_col_i, whatever the length code. Reads (cmd_write_i = 0) keep the programmed length and order.
- R7: When stop_i is high at a clock edge while a burst is active and start_i is low, valid_o is 0 from that edge on. No further column is issued.
- R8: start_i is accepted on any clock, including during a burst and together with stop_i. The new burst replaces the old one, and its first column appears on the next clock.
- R9: last_o is high exactly on the final beat of a burst, and never while valid_o is low.
- R10: The reserved length codes 4, 5 and 6 behave as a burst of one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Read or write command present this cycle |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| start_col_i | input | 9 | Starting column |
| blen_i | input | 3 | Length code: 0/1/2/3 = 1/2/4/8 beats, 7 = full page |
| burst_type_i | input | 1 | 0 = sequential, 1 = interleaved |
| single_wr_i | input | 1 | Writes become single-beat bursts |
| stop_i | input | 1 | Terminate the burst in progress |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | col_o carries a beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
The bench starts bursts one column below a block edge and at the top of the column space, so a design that carries into the upper bits in sequential mode would leave the aligned block, and one that adds instead of XORing in interleaved mode would issue the wrong order. It runs a full-page burst across column 511 with interleaving requested. A design that honoured the ordering there, or stopped at the top column, or raised last_o, would fail. It issues single-beat-write mode with both a write and a read, which catches a design that also shortens reads or ignores the switch. It also issues back-to-back commands, a command together with stop, and a stop in the middle of a burst. A design that gave stop priority, or kept issuing columns after a stop, would show the wrong valid_o or col_o.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int COL_W   = 9;
  localparam int BL_W    = 3;
  localparam int MAX_LOG = 3;
  localparam logic [BL_W-1:0] FULL_CODE = 3'd7;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_ITL = 1'b1} order_e;
endpackage

// File: rtl/blen_decode.sv
module blen_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W_P   = COL_W,
  parameter int BL_W_P    = BL_W,
  parameter int MAX_LOG_P = MAX_LOG,
  parameter logic [BL_W_P-1:0] FULL_CODE_P = FULL_CODE
) (
  input  logic [BL_W_P-1:0]  code_i,
  input  logic               itl_i,
  input  logic               write_i,
  input  logic               single_wr_i,
  output logic [COL_W_P-1:0] mask_o,
  output logic               full_o,
  output logic               itl_o
);
  always_comb begin
    full_o = (code_i == FULL_CODE_P);
    mask_o = '0;
    if (full_o) mask_o = '1;
    else begin
      for (int k = 1; k <= MAX_LOG_P; k++)
        if (code_i == BL_W_P'(k)) mask_o = COL_W_P'((1 << k) - 1);
    end
    // single-beat writes override length
    if (write_i && single_wr_i) begin
      mask_o = '0;
      full_o = 1'b0;
    end
    itl_o = itl_i && !full_o;
  end
endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W_P = COL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [COL_W_P-1:0] col_i,
  input  logic [COL_W_P-1:0] mask_i,
  input  logic               full_i,
  input  logic               itl_i,
  output logic               active_o,
  output logic               last_o,
  output logic [COL_W_P-1:0] base_o,
  output logic [COL_W_P-1:0] cnt_o,
  output logic [COL_W_P-1:0] mask_o,
  output logic               itl_o
);
  logic               active_q, full_q, itl_q;
  logic [COL_W_P-1:0] base_q, cnt_q, mask_q;
  logic               last_w;

  assign last_w = active_q && !full_q && (cnt_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      itl_q    <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_i;
      itl_q    <= itl_i;
      base_q   <= col_i;
      cnt_q    <= '0;
      mask_q   <= mask_i;
    end else if (active_q) begin
      if (stop_i || last_w) active_q <= 1'b0;
      else                  cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign last_o   = last_w;
  assign base_o   = base_q;
  assign cnt_o    = cnt_q;
  assign mask_o   = mask_q;
  assign itl_o    = itl_q;

  assert_stop_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && stop_i && !start_i) |=> !active_q);
  assert_start_restarts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_q && cnt_q == '0 && base_q == $past(col_i)));
  assert_beat_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !last_w && !stop_i && !start_i) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/col_calc.sv
module col_calc
  import burst_col_pkg::*;
#(
  parameter int COL_W_P = COL_W
) (
  input  logic [COL_W_P-1:0] base_i,
  input  logic [COL_W_P-1:0] cnt_i,
  input  logic [COL_W_P-1:0] mask_i,
  input  logic               itl_i,
  output logic [COL_W_P-1:0] col_o
);
  logic [COL_W_P-1:0] seq_col, itl_col;

  assign seq_col = (base_i & ~mask_i) | ((base_i + cnt_i) & mask_i);
  assign itl_col = base_i ^ (cnt_i & mask_i);
  assign col_o   = (itl_i == ORD_ITL) ? itl_col : seq_col;

  always_comb begin
    assert_block_fixed_R3: assert ((col_o & ~mask_i) == (base_i & ~mask_i));
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W_P   = COL_W,
  parameter int BL_W_P    = BL_W,
  parameter int MAX_LOG_P = MAX_LOG,
  parameter logic [BL_W_P-1:0] FULL_CODE_P = FULL_CODE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               cmd_write_i,
  input  logic [COL_W_P-1:0] start_col_i,
  input  logic [BL_W_P-1:0]  blen_i,
  input  logic               burst_type_i,
  input  logic               single_wr_i,
  input  logic               stop_i,
  output logic [COL_W_P-1:0] col_o,
  output logic               valid_o,
  output logic               last_o
);
  logic [COL_W_P-1:0] dec_mask, base, cnt, mask;
  logic               dec_full, dec_itl, itl;

  blen_decode #(
    .COL_W_P(COL_W_P), .BL_W_P(BL_W_P), .MAX_LOG_P(MAX_LOG_P), .FULL_CODE_P(FULL_CODE_P)
  ) u_dec (
    .code_i(blen_i), .itl_i(burst_type_i), .write_i(cmd_write_i),
    .single_wr_i(single_wr_i), .mask_o(dec_mask), .full_o(dec_full), .itl_o(dec_itl)
  );

  beat_ctrl #(.COL_W_P(COL_W_P)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .col_i(start_col_i), .mask_i(dec_mask), .full_i(dec_full), .itl_i(dec_itl),
    .active_o(valid_o), .last_o(last_o), .base_o(base), .cnt_o(cnt),
    .mask_o(mask), .itl_o(itl)
  );

  col_calc #(.COL_W_P(COL_W_P)) u_calc (
    .base_i(base), .cnt_i(cnt), .mask_i(mask), .itl_i(itl), .col_o(col_o)
  );

  assert_last_closes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && last_o && !start_i) |=> !valid_o);
  assert_single_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cmd_write_i && single_wr_i) |=> (valid_o && last_o && col_o == $past(start_col_i)));
  assert_first_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));
endmodule

// File: tb/tb_burst_col_gen.sv
module tb_burst_col_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NV = 11;

  // stimulus table: length code, interleave, write, single-write mode, start column
  localparam logic [2:0] V_BL  [NV] = '{3'd2, 3'd2, 3'd3, 3'd3, 3'd1, 3'd1, 3'd0, 3'd3, 3'd2, 3'd2, 3'd5};
  localparam logic       V_ITL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic       V_WR  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic       V_SWM [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [8:0] V_COL [NV] = '{9'h005, 9'h005, 9'h1FD, 9'h0A3, 9'h011, 9'h010, 9'h0FF, 9'h033, 9'h102, 9'h00E, 9'h077};
  localparam int         V_LEN [NV] = '{4, 4, 8, 8, 2, 2, 1, 1, 4, 4, 1};
  localparam logic [8:0] V_EXP [NV][8] = '{
    '{9'h005, 9'h006, 9'h007, 9'h004, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h005, 9'h004, 9'h007, 9'h006, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h1FD, 9'h1FE, 9'h1FF, 9'h1F8, 9'h1F9, 9'h1FA, 9'h1FB, 9'h1FC},
    '{9'h0A3, 9'h0A2, 9'h0A1, 9'h0A0, 9'h0A7, 9'h0A6, 9'h0A5, 9'h0A4},
    '{9'h011, 9'h010, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h010, 9'h011, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h0FF, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h033, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h102, 9'h103, 9'h100, 9'h101, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h00E, 9'h00F, 9'h00C, 9'h00D, 9'h000, 9'h000, 9'h000, 9'h000},
    '{9'h077, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000, 9'h000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, wr = 1'b0, itl = 1'b0, swm = 1'b0, stop = 1'b0;
  logic [8:0] scol = '0;
  logic [2:0] bl = '0;
  logic [8:0] col;
  logic       valid, last;
  int         n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_write_i(wr),
    .start_col_i(scol), .blen_i(bl), .burst_type_i(itl), .single_wr_i(swm),
    .stop_i(stop), .col_o(col), .valid_o(valid), .last_o(last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [8:0] exp_col, input bit exp_last, input string req);
    chk(valid === 1'b1 && col === exp_col, req, {22'd0, valid, col}, {23'd1, exp_col});
    chk(last === exp_last, "R9", 32'(last), 32'(exp_last));
  endtask

  task automatic issue(input logic [2:0] b, input logic i, input logic w, input logic s, input logic [8:0] c);
    start = 1'b1; bl = b; itl = i; wr = w; swm = s; scol = c;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk(valid === 1'b0 && last === 1'b0, "R1", {30'd0, valid, last}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R6 R10
    for (int v = 0; v < NV; v++) begin
      tag = V_SWM[v] ? "R6" : (V_BL[v] > 3'd3) ? "R10" : V_ITL[v] ? "R4" : "R3";
      issue(V_BL[v], V_ITL[v], V_WR[v], V_SWM[v], V_COL[v]);
      @(negedge clk);
      start = 1'b0;
      for (int b = 0; b < V_LEN[v]; b++) begin
        if (b > 0) @(negedge clk);
        beat(V_EXP[v][b], b == V_LEN[v] - 1, tag);
      end
      @(negedge clk);
      chk(valid === 1'b0, "R2", 32'(valid), 32'd0);
    end

    // R5: full page across 511 -> 0, interleave ignored, then stop (R7)
    issue(3'd7, 1'b1, 1'b0, 1'b0, 9'h1FE);
    @(negedge clk);
    start = 1'b0;
    for (int b = 0; b < 6; b++) begin
      if (b > 0) @(negedge clk);
      beat(9'(9'h1FE + b), 1'b0, "R5");
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(valid === 1'b0, "R7", 32'(valid), 32'd0);

    // R7: stop in the middle of an 8-beat burst
    issue(3'd3, 1'b0, 1'b0, 1'b0, 9'h040);
    @(negedge clk);
    start = 1'b0;
    for (int b = 0; b < 3; b++) begin
      if (b > 0) @(negedge clk);
      beat(9'(9'h040 + b), 1'b0, "R7");
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk(valid === 1'b0 && last === 1'b0, "R7", {30'd0, valid, last}, 32'd0);
    @(negedge clk);
    chk(valid === 1'b0, "R7", 32'(valid), 32'd0);

    // R8: back-to-back commands, and start together with stop
    issue(3'd3, 1'b0, 1'b0, 1'b0, 9'h100);
    @(negedge clk);
    beat(9'h100, 1'b0, "R8");
    issue(3'd2, 1'b1, 1'b0, 1'b0, 9'h055);
    @(negedge clk);
    beat(9'h055, 1'b0, "R8");
    issue(3'd0, 1'b0, 1'b0, 1'b0, 9'h1C0);
    stop = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop = 1'b0;
    beat(9'h1C0, 1'b1, "R8");
    @(negedge clk);
    chk(valid === 1'b0 && last === 1'b0, "R9", {30'd0, valid, last}, 32'd0);

    finish_run();
  end
endmodule